// File: doc/BRIEF.md
# Clock Generator Configuration Slave (two-wire, block write)

This block is a slave on a two-wire serial bus (SMBus framing: START, STOP, 8-bit address, ACK/NACK) that holds the control registers of a clock generator. A write sends the device write address, then a command byte whose value has no effect, then a byte-count byte, and then data bytes. The data bytes fill the control registers one after another, starting at register 0. A read at the device read address returns the registers in the same order, most significant bit first.

Some register bits are stored and can be written. The other bits are read-only and show the current level of external strap and control pins. The bus lines are sampled with a two-stage synchroniser in the system clock domain. The slave only pulls SDA low (open-drain style), and only changes SDA while SCL is low. The register contents drive the generator directly through three parallel outputs, which show the same merged view that a read returns.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: After reset, SDA is released and the stored bits hold their defaults. Register 0 bits 7..5 are 0 and bit 3 (the PCI-stop enable) is 1. Register 1 bits 6..3 are 0 and bits 2..0 are 1. Register 2 is 0x00.
- R2: The 8-bit address 0xD2 (write) and the 8-bit address 0xD3 (read) are acknowledged by pulling SDA low in the ninth clock. Any other address gets no acknowledge, and the slave ignores the rest of that transaction.
- R3: In a write, the two bytes after the address are the command byte and the byte-count byte. Both are acknowledged, and neither value changes any register.
- R4: The data bytes that follow the byte count are each acknowledged. The first goes to register 0, the second to register 1 and the third to register 2.
- R5: Writes to the read-only positions have no effect. These positions return live pin levels. In register 0, bits 2..0 show the three frequency-select pins and bit 4 shows the CPU-stop pin. In register 1, bit 7 shows the multiplier pin.
- R6: Data bytes after the third are acknowledged and then discarded.
- R7: Register 0 bit 3 shows the logical AND of the stored PCI-stop enable bit and the external PCI-stop pin. This combined value is the effective internal PCI-stop signal.
- R8: A read returns register 0, then 1, then 2, most significant bit first. Any byte after register 2 reads 0xFF. A master NACK ends the read, and the slave releases SDA.
- R9: The slave changes its SDA drive only while SCL is low.
- R10: After a STOP, the slave ignores the bus until the next START. A repeated START restarts address decoding. The registers keep their values across transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| fsel_i | input | 3 | Frequency-select strap pins |
| mult_i | input | 1 | Multiplier strap pin |
| cpu_stop_i | input | 1 | External CPU-stop pin level |
| pci_stop_i | input | 1 | External PCI-stop pin level |
| cfg0_o | output | 8 | Merged view of register 0 |
| cfg1_o | output | 8 | Merged view of register 1 |
| cfg2_o | output | 8 | Merged view of register 2 |

## Verification
The bench targets several corner cases, and each one shows a specific failure:
- A foreign address followed by more bytes. A slave that decodes the address loosely would acknowledge these bytes or change registers.
- A write with more than three data bytes. An index that is not saturated would wrap and overwrite register 0.
- Data that sets the read-only and combined bit positions. An incorrect write mask would hide the live pin levels.
- A read that runs past register 2 and ends with a NACK, plus a repeated START inside a write. A slave that keeps driving SDA, or that does not restart addressing, would return the wrong bytes or hold the line low.

// File: rtl/clkcfg_pkg.sv
// Package: shared constants and types for the clock-generator configuration slave.
// Assumes at least three registers; registers above 2 are fully writable.
package clkcfg_pkg;
    localparam int           BYTE_W    = 8;
    localparam int           NUM_REGS  = 3;
    localparam int           IDX_W     = $clog2(NUM_REGS + 1);
    localparam int           CNT_W     = $clog2(NUM_REGS + 3);
    localparam logic [6:0]   DEV_ADDR  = 7'h69;   // 0xD2 write / 0xD3 read
    localparam logic [7:0]   RD_FILL   = 8'hFF;

    typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WRITE, ST_READ} bus_state_e;

    // Writable bit mask of register i.
    function automatic logic [7:0] reg_wmask(input int i);
        if (i == 0)      return 8'hE8;
        else if (i == 1) return 8'h7F;
        else             return 8'hFF;
    endfunction

    // Power-up value of the stored bits of register i.
    function automatic logic [7:0] reg_rstval(input int i);
        if (i == 0)      return 8'h08;
        else if (i == 1) return 8'h07;
        else             return 8'h00;
    endfunction
endpackage

// File: rtl/smb_line_sync.sv
// Module: synchronises SCL/SDA into clk and flags SCL edges and START/STOP.
// Assumes the bus is several clk periods per SCL phase; lines idle high.
module smb_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [SYNC_STAGES:0] scl_sh;
    logic [SYNC_STAGES:0] sda_sh;

    // Shift both lines through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-1:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-1:0], sda_i};
        end
    end

    // Derive levels, SCL edges and SDA-while-SCL-high conditions.
    always_comb begin
        scl_o      = scl_sh[SYNC_STAGES-1];
        sda_o      = sda_sh[SYNC_STAGES-1];
        scl_rise_o = scl_o & ~scl_sh[SYNC_STAGES];
        scl_fall_o = ~scl_o & scl_sh[SYNC_STAGES];
        start_o    = scl_o & scl_sh[SYNC_STAGES] & sda_sh[SYNC_STAGES] & ~sda_o;
        stop_o     = scl_o & scl_sh[SYNC_STAGES] & ~sda_sh[SYNC_STAGES] & sda_o;
    end
endmodule

// File: rtl/smb_slave_fsm.sv
// Module: bit/byte protocol engine. Decodes the address, acknowledges bytes,
// issues register writes for data bytes and serialises read data.
// Assumes edge/START/STOP strobes are single-cycle and come from one synchroniser.
module smb_slave_fsm
    import clkcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl,
    input  logic             sda,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start,
    input  logic             stop,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             sda_oe
);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(NUM_REGS + 2);
    localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(2);
    localparam logic [IDX_W-1:0] IDX_MAX  = IDX_W'(NUM_REGS);

    bus_state_e       state;
    logic [3:0]       bit_cnt;
    logic [7:0]       shreg;
    logic             in_ack;
    logic             is_read;
    logic             mnack;
    logic [CNT_W-1:0] byte_n;
    logic [IDX_W-1:0] rd_next;

    assign rd_next = (rd_idx == IDX_MAX) ? rd_idx : rd_idx + 1'b1;

    // Main protocol state machine, stepped by synchronised SCL edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            in_ack  <= 1'b0;
            is_read <= 1'b0;
            mnack   <= 1'b0;
            byte_n  <= '0;
            rd_idx  <= '0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
            sda_oe  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                in_ack  <= 1'b0;
                sda_oe  <= 1'b0;
                byte_n  <= '0;
                rd_idx  <= '0;
            end else if (stop) begin
                state  <= ST_IDLE;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WRITE: begin
                        if (scl_rise && !in_ack && bit_cnt != 4'd8) begin
                            shreg   <= {shreg[6:0], sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && in_ack) begin
                            in_ack  <= 1'b0;
                            bit_cnt <= '0;
                            sda_oe  <= 1'b0;
                            if (state == ST_ADDR) begin
                                if (is_read) begin
                                    state  <= ST_READ;
                                    shreg  <= rd_data;
                                    sda_oe <= ~rd_data[7];
                                    rd_idx <= rd_next;
                                end else begin
                                    state <= ST_WRITE;
                                end
                            end
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    in_ack  <= 1'b1;
                                    sda_oe  <= 1'b1;
                                    is_read <= shreg[0];
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                in_ack <= 1'b1;
                                sda_oe <= 1'b1;
                                if (byte_n >= CNT_DATA && byte_n < CNT_MAX) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= IDX_W'(byte_n - CNT_DATA);
                                    wr_data <= shreg;
                                end
                                if (byte_n != CNT_MAX) byte_n <= byte_n + 1'b1;
                            end
                        end
                    end
                    ST_READ: begin
                        if (scl_rise) begin
                            if (in_ack) mnack <= sda;
                            else if (bit_cnt != 4'd8) bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (in_ack) begin
                                in_ack  <= 1'b0;
                                bit_cnt <= '0;
                                if (mnack) begin
                                    state  <= ST_IDLE;
                                    sda_oe <= 1'b0;
                                end else begin
                                    shreg  <= rd_data;
                                    sda_oe <= ~rd_data[7];
                                    rd_idx <= rd_next;
                                end
                            end else if (bit_cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                in_ack <= 1'b1;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // SDA drive may only move while the synchronised SCL was low.
    p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl));

    // An idle slave never holds the data line.
    p_idle_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // A register write is issued only together with its acknowledge.
    p_write_on_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (in_ack && sda_oe));

    // Entering an address acknowledge requires the device address.
    p_addr_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(in_ack) && state == ST_ADDR) |-> (shreg[7:1] == DEV_ADDR));
endmodule

// File: rtl/cfg_regfile.sv
// Module: control register file. Stores writable bits, holds read-only bit
// positions at their defaults, and merges live pin levels into the read view.
// Assumes pins are quasi-static (straps and slow control levels).
module cfg_regfile
    import clkcfg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [7:0]               wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    input  logic [2:0]               fsel,
    input  logic                     mult,
    input  logic                     cpu_stop,
    input  logic                     pci_stop,
    output logic [7:0]               rd_data,
    output logic [NUM_REGS*8-1:0]    view_flat
);
    logic [7:0] stor [NUM_REGS];
    logic [7:0] view [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [7:0] WM = reg_wmask(g);
        localparam logic [7:0] RV = reg_rstval(g);

        // Update writable bits of this register on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   stor[g] <= RV;
            else if (wr_en && wr_idx == IDX_W'(g))        stor[g] <= (wr_data & WM) | (stor[g] & ~WM);
        end

        if (g == 0) begin : g_merge0
            // Register 0: stored controls, CPU-stop pin, gated PCI-stop, strap pins.
            assign view[g] = (stor[g] & 8'hE0) | {3'b000, cpu_stop, stor[g][3] & pci_stop, fsel};
        end else if (g == 1) begin : g_merge1
            // Register 1: multiplier strap on top, stored controls below.
            assign view[g] = (stor[g] & 8'h7F) | {mult, 7'b0};
        end else begin : g_plain
            assign view[g] = stor[g];
        end

        assign view_flat[g*8 +: 8] = view[g];

        // A write lands in the writable bits on the next cycle.
        p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(g)) |=> ((stor[g] & WM) == ($past(wr_data) & WM)));

        // Without a write the register keeps its value.
        p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == IDX_W'(g)) |=> $stable(stor[g]));
    end

    // Select the byte for the read shifter; beyond the last register return fill.
    always_comb begin
        rd_data = RD_FILL;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_idx == IDX_W'(i)) rd_data = view[i];
    end
endmodule

// File: rtl/clkgen_cfg_slave.sv
// Module: top of the configuration slave. Wires the line synchroniser, the
// protocol engine and the register file; SDA is open-drain via sda_oe_o.
// Assumes an external pull-up and open-drain drivers on SDA and SCL.
module clkgen_cfg_slave
    import clkcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] fsel_i,
    input  logic       mult_i,
    input  logic       cpu_stop_i,
    input  logic       pci_stop_i,
    output logic [7:0] cfg0_o,
    output logic [7:0] cfg1_o,
    output logic [7:0] cfg2_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
    logic wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [7:0] wr_data, rd_data;
    logic [NUM_REGS*8-1:0] view_flat;

    smb_line_sync #(.SYNC_STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start), .stop_o(stop)
    );

    smb_slave_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start(start), .stop(stop),
        .rd_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .sda_oe(sda_oe_o)
    );

    cfg_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .fsel(fsel_i), .mult(mult_i), .cpu_stop(cpu_stop_i),
        .pci_stop(pci_stop_i), .rd_data(rd_data), .view_flat(view_flat)
    );

    assign cfg0_o = view_flat[7:0];
    assign cfg1_o = view_flat[15:8];
    assign cfg2_o = view_flat[23:16];
endmodule

// File: tb/clkgen_cfg_slave_tb.sv
module clkgen_cfg_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;      // clk cycles per quarter SCL period
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic mlow  = 1'b0;
    logic [2:0] fsel = 3'b101;
    logic mult = 1'b0, cpu_stop = 1'b1, pci_stop = 1'b1;
    logic dut_oe;
    logic sda_line;
    logic [7:0] cfg0, cfg1, cfg2;

    int checks = 0, errors = 0, cycles = 0, r9_viol = 0;
    bit cmp_en = 1'b0, done = 1'b0;
    logic [7:0] mreg [3];   // reference model of the stored bits
    logic prev_oe = 1'b0;

    assign sda_line = !(mlow | dut_oe);

    always #(CLK_PERIOD/2) clk = ~clk;

    clkgen_cfg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(dut_oe),
        .fsel_i(fsel), .mult_i(mult), .cpu_stop_i(cpu_stop), .pci_stop_i(pci_stop),
        .cfg0_o(cfg0), .cfg1_o(cfg1), .cfg2_o(cfg2)
    );

    function automatic logic [7:0] wmask(int i);
        return (i == 0) ? 8'hE8 : (i == 1) ? 8'h7F : 8'hFF;
    endfunction

    function automatic logic [7:0] exp_view(int i);
        if (i == 0) return {mreg[0][7:5], cpu_stop, mreg[0][3] & pci_stop, fsel};
        if (i == 1) return {mult, mreg[1][6:0]};
        if (i == 2) return mreg[2];
        return 8'hFF;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        cmp_en = 1'b0;
        mlow = 1'b0; wait_q(1);
        scl_m = 1'b1; wait_q(2);
        mlow = 1'b1; wait_q(2);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic bus_stop();
        mlow = 1'b1; wait_q(1);
        scl_m = 1'b1; wait_q(2);
        mlow = 1'b0; wait_q(4);
    endtask

    task automatic send_bit(input logic b);
        mlow = !b; wait_q(1);
        scl_m = 1'b1; wait_q(2);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic recv_bit(output logic v);
        mlow = 1'b0; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        v = sda_line; wait_q(1);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic v;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(v);
        ack = !v;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(v);
            d[i] = v;
        end
        send_bit(!give_ack);
    endtask

    // Full write: address, command, count, data bytes, STOP; model updated after.
    task automatic write_txn(input string req, input logic [7:0] cmd, input logic [7:0] data[$]);
        logic ack;
        bus_start();
        send_byte(8'hD2, ack);  chk("R2 write address ack", ack, 1);
        send_byte(cmd, ack);    chk("R3 command byte ack", ack, 1);
        send_byte(8'(data.size()), ack); chk("R3 count byte ack", ack, 1);
        foreach (data[k]) begin
            send_byte(data[k], ack);
            chk(req, ack, 1);
            if (k < 3) mreg[k] = (data[k] & wmask(k)) | (mreg[k] & ~wmask(k));
        end
        bus_stop();
        cmp_en = 1'b1;
    endtask

    task automatic check_cfg(input string req);
        chk(req, cfg0, exp_view(0));
        chk(req, cfg1, exp_view(1));
        chk(req, cfg2, exp_view(2));
    endtask

    // Reference comparison on every clock while the bus is idle.
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            checks++;
            if (cfg0 !== exp_view(0) || cfg1 !== exp_view(1) || cfg2 !== exp_view(2)) begin
                errors++;
                $display("FAIL R10 idle compare: actual %h %h %h expected %h %h %h",
                         cfg0, cfg1, cfg2, exp_view(0), exp_view(1), exp_view(2));
            end
        end
    end

    // R9 monitor: slave drive must not move while SCL is high.
    always @(posedge clk) begin
        if (rst_n && dut_oe !== prev_oe && scl_m) r9_viol++;
        prev_oe <= dut_oe;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] d;
        mreg[0] = 8'h08; mreg[1] = 8'h07; mreg[2] = 8'h00;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R1: reset values and released line
        check_cfg("R1 reset view");
        chk("R1 sda released", dut_oe, 0);
        cmp_en = 1'b1;

        // R4: three data bytes land in order
        write_txn("R4 data byte ack", 8'h3C, '{8'hFF, 8'hFF, 8'h5A});
        check_cfg("R4 registers after write");
        chk("R4 reg0 merged", cfg0, 8'hFD);

        // R5 / R3: write read-only positions with a different command value
        write_txn("R4 data byte ack", 8'hC3, '{8'h17, 8'h80});
        check_cfg("R5 read-only writes ignored");
        chk("R5 reg1 bit7 is pin", cfg1[7], 0);
        chk("R10 reg2 retained", cfg2, 8'h5A);

        // R5: live pins reflected
        fsel = 3'b010; mult = 1'b1; cpu_stop = 1'b0;
        repeat (3) @(negedge clk);
        check_cfg("R5 live pins");
        chk("R5 fsel bits", cfg0[2:0], 3'b010);

        // R7: AND of stored bit and pin
        write_txn("R4 data byte ack", 8'h00, '{8'h08});
        chk("R7 bit3 both high", cfg0[3], 1);
        pci_stop = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 bit3 pin low", cfg0[3], 0);
        pci_stop = 1'b1;
        write_txn("R4 data byte ack", 8'h00, '{8'h00});
        chk("R7 bit3 stored low", cfg0[3], 0);

        // R2: foreign address is not acknowledged and changes nothing
        bus_start();
        send_byte(8'hA0, ack); chk("R2 foreign address nack", ack, 0);
        send_byte(8'h00, ack); chk("R2 later byte nack", ack, 0);
        send_byte(8'hFF, ack); chk("R2 later byte nack", ack, 0);
        bus_stop();
        cmp_en = 1'b1;
        repeat (3) @(negedge clk);
        check_cfg("R2 no change after foreign address");

        // R6: extra data bytes acknowledged but discarded
        write_txn("R6 extra byte ack", 8'h11, '{8'h20, 8'h41, 8'h99, 8'h11, 8'h22});
        check_cfg("R6 extra bytes discarded");
        chk("R6 reg2 first value kept", cfg2, 8'h99);

        // R8: read registers in order, fill byte, NACK releases
        bus_start();
        send_byte(8'hD3, ack); chk("R8 read address ack", ack, 1);
        for (int i = 0; i < 4; i++) begin
            recv_byte(i < 3, d);
            chk("R8 read byte", d, exp_view(i));
        end
        wait_q(1);
        chk("R8 released after nack", dut_oe, 0);
        bus_stop();
        cmp_en = 1'b1;

        // R10: repeated start restarts addressing
        bus_start();
        send_byte(8'hD2, ack); chk("R10 write address ack", ack, 1);
        send_byte(8'h00, ack); chk("R3 command byte ack", ack, 1);
        bus_start();
        send_byte(8'hD3, ack); chk("R10 read after repeated start", ack, 1);
        recv_byte(1'b0, d);
        chk("R10 first byte after restart", d, exp_view(0));
        bus_stop();
        cmp_en = 1'b1;

        // R10: after STOP, bytes without START are ignored
        cmp_en = 1'b0;
        send_byte(8'hD2, ack); chk("R10 no ack without start", ack, 0);
        mlow = 1'b0; scl_m = 1'b1; wait_q(4);
        cmp_en = 1'b1;
        check_cfg("R10 registers retained");

        chk("R9 sda moved with scl high", r9_viol, 0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule